// File: doc/BRIEF.md
# Baud Tick Generator with Auto-Reload Timer

This block produces the sampling strobe that a UART receiver oversampler and transmitter bit divider run from. The system clock first passes through a machine-cycle prescaler, which divides by 12 or by 6 depending on the selected clock mode. The machine-cycle enable then advances a reload counter. The counter counts up from a programmed start value and reloads that value each time it overflows. Overflows pass through a final stage controlled by a rate-doubling input. With doubling off, every second overflow gives a tick. With doubling on, every overflow gives a tick. The tick rate is therefore sixteen times the serial bit rate, so one bit time holds sixteen ticks.

The counter runs in one of two widths. In the narrow width, only the low reload byte is used and the counter wraps after 256 minus that byte machine cycles. This is the usual way to produce standard rates such as 9600 baud from an 11.059 MHz clock with a start value of 0xFD. In the wide width, both reload bytes form a 16-bit start value, which reaches very slow rates such as 110 baud.

When the run input is low, the block is held idle: the counter keeps loading the reload value and the prescaler stays cleared.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `tick` is low.
- R2: With `short_mc`=0, `dbl`=0 and `wide`=0, `tick` pulses every 24*(256-`rld_lo`) clock cycles. `rld_hi` has no effect in this width. Example: 0xFD gives 72 cycles and 0x00 gives 6144 cycles.
- R3: Setting `dbl`=1 halves the tick period to 12*(256-`rld_lo`) cycles with `short_mc`=0.
- R4: With `short_mc`=1, the machine cycle is 6 clocks instead of 12, so every tick period is halved for the same settings.
- R5: With `wide`=1, the start value is {`rld_hi`,`rld_lo`} and the tick period is M*(65536-start)*(2-`dbl`), where M is 12 or 6. Example: 0xFEEB with M=12 and `dbl`=0 gives 6648 cycles.
- R6: `tick` is high for exactly one clock cycle.
- R7: While `run` is low, no tick occurs and the counter restarts from the reload value. Take the first rising edge that samples `run` high as edge 1. The first tick is then registered at edge P, where P is the tick period.
- R8: A reload value written while running does not change the count in progress. It takes effect from the next overflow.
- R9: The fastest setting (`rld_lo`=0xFF, `dbl`=1) gives one tick per machine cycle. That is 12 clocks, or 6 clocks with `short_mc`=1, and no two ticks are ever closer than 6 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Timer run enable |
| short_mc | input | 1 | 1: 6 clocks per machine cycle; 0: 12 clocks |
| dbl | input | 1 | Rate doubling: 1 ticks on every overflow, 0 on every second overflow |
| wide | input | 1 | 1: 16-bit counter with start {rld_hi,rld_lo}; 0: 8-bit counter with start rld_lo |
| rld_hi | input | 8 | Upper reload byte (used only in the 16-bit width) |
| rld_lo | input | 8 | Lower reload byte |
| tick | output | 1 | One-cycle strobe at 16x the bit rate |

## Verification
The hardest case to reach is a reload change that lands between overflows. The new value must stay out of the count already loaded and then govern the period after it. The bench runs the timer at a short period and aligns to an observed tick. It writes a new reload byte on the falling edge right after that tick, then checks that the next interval still uses the old value and the one after uses the new value. The 16-bit width needs a long interval before it overflows, so the bench uses the real slow setting and still waits for two full periods.

// File: rtl/brt_pkg.sv
package brt_pkg;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 2 * BYTE_W;
    localparam int MC_LONG  = 12;
    localparam int MC_SHORT = 6;
    localparam int PRE_W    = $clog2(MC_LONG);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;

    typedef struct packed {
        logic half;
        logic tick;
    } div_state_t;
endpackage

// File: rtl/brt_prescale.sv
module brt_prescale
    import brt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic short_mc,
    output logic mc_en
);
    pre_state_t s_d, s_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit = short_mc ? PRE_W'(MC_SHORT - 1) : PRE_W'(MC_LONG - 1);
        mc_en = run && (s_q.cnt >= limit);
        s_d   = s_q;
        if (!run || mc_en) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/brt_reload_ctr.sv
module brt_reload_ctr
    import brt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              mc_en,
    input  logic              wide,
    input  logic [BYTE_W-1:0] rld_hi,
    input  logic [BYTE_W-1:0] rld_lo,
    output logic              ovf
);
    ctr_state_t s_d, s_q;
    logic [CNT_W-1:0] start_val;
    logic             at_top;

    always_comb begin
        start_val = wide ? {rld_hi, rld_lo} : {{BYTE_W{1'b0}}, rld_lo};
        at_top    = wide ? (&s_q.cnt) : (&s_q.cnt[BYTE_W-1:0]);
        ovf       = mc_en && at_top;
        s_d       = s_q;
        if (!run || ovf) begin
            s_d.cnt = start_val;
        end else if (mc_en) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/brt_post_div.sv
module brt_post_div
    import brt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ovf,
    input  logic dbl,
    output logic tick
);
    div_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.tick = 1'b0;
        if (!run) begin
            s_d.half = 1'b0;
        end else if (ovf) begin
            if (dbl) begin
                s_d.tick = 1'b1;
                s_d.half = 1'b0;
            end else begin
                s_d.tick = s_q.half;
                s_d.half = ~s_q.half;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.tick;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import brt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              short_mc,
    input  logic              dbl,
    input  logic              wide,
    input  logic [BYTE_W-1:0] rld_hi,
    input  logic [BYTE_W-1:0] rld_lo,
    output logic              tick
);
    logic mc_en;
    logic ovf;

    brt_prescale u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .short_mc (short_mc),
        .mc_en    (mc_en)
    );

    brt_reload_ctr u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .mc_en  (mc_en),
        .wide   (wide),
        .rld_hi (rld_hi),
        .rld_lo (rld_lo),
        .ovf    (ovf)
    );

    brt_post_div u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .ovf   (ovf),
        .dbl   (dbl),
        .tick  (tick)
    );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic tick,
    input logic mc_en,
    input logic ovf
);
    logic [7:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      gap_q <= 8'hFF;
        else if (tick)   gap_q <= 8'h00;
        else if (gap_q != 8'hFF) gap_q <= gap_q + 8'h01;
    end

    p_tick_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    p_idle_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick);

    p_ovf_on_mc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> mc_en);

    p_tick_after_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(ovf));

    p_min_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap_q >= 8'd5));
endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick),
    .mc_en (mc_en),
    .ovf   (ovf)
);

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       short_mc = 1'b0;
    logic       dbl = 1'b0;
    logic       wide = 1'b0;
    logic [7:0] rld_hi = 8'h00;
    logic [7:0] rld_lo = 8'h00;
    logic       tick;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    baud_tick_gen u_baud_tick_gen (
        .clk(clk), .rst_n(rst_n), .run(run), .short_mc(short_mc), .dbl(dbl),
        .wide(wide), .rld_hi(rld_hi), .rld_lo(rld_lo), .tick(tick)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_tick(output int n, input int limit);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick && n < limit);
    endtask

    task automatic start(input logic s, input logic d, input logic w,
                         input logic [7:0] hi, input logic [7:0] lo);
        @(negedge clk);
        run = 1'b0;
        short_mc = s; dbl = d; wide = w; rld_hi = hi; rld_lo = lo;
        repeat (3) @(negedge clk);
        run = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 tick low after reset", int'(tick), 0);
    endtask

    task automatic t_rate(input string tag, input logic s, input logic d, input logic w,
                          input logic [7:0] hi, input logic [7:0] lo, input int exp);
        int n;
        start(s, d, w, hi, lo);
        wait_tick(n, exp + 50);
        check({"R7 first tick latency / ", tag}, n, exp);
        @(negedge clk);
        check("R6 tick one cycle", int'(tick), 0);
        wait_tick(n, exp + 50);
        check({tag, " period"}, n + 1, exp);
    endtask

    task automatic t_idle();
        int cnt = 0;
        start(1'b1, 1'b1, 1'b0, 8'h00, 8'hFF);
        repeat (20) @(negedge clk);
        run = 1'b0;
        repeat (300) begin
            @(negedge clk);
            if (tick) cnt++;
        end
        check("R7 no tick while run low", cnt, 0);
    endtask

    task automatic t_reload_change();
        int n;
        start(1'b0, 1'b1, 1'b0, 8'h00, 8'hFD);
        wait_tick(n, 100);
        check("R8 first period", n, 36);
        rld_lo = 8'hFA;
        wait_tick(n, 200);
        check("R8 old reload still in force", n, 36);
        wait_tick(n, 200);
        check("R8 new reload after overflow", n, 72);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rate("R2 FD", 1'b0, 1'b0, 1'b0, 8'h12, 8'hFD, 72);
        t_rate("R2 FA", 1'b0, 1'b0, 1'b0, 8'h00, 8'hFA, 144);
        t_rate("R2 E8", 1'b0, 1'b0, 1'b0, 8'h00, 8'hE8, 576);
        t_rate("R2 00", 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 6144);
        t_rate("R3 FD doubled", 1'b0, 1'b1, 1'b0, 8'h00, 8'hFD, 36);
        t_rate("R9 FF fastest", 1'b0, 1'b1, 1'b0, 8'h00, 8'hFF, 12);
        t_rate("R4 short FD", 1'b1, 1'b0, 1'b0, 8'h00, 8'hFD, 36);
        t_rate("R9 short FF fastest", 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 6);
        t_rate("R5 wide FEEB", 1'b0, 1'b0, 1'b1, 8'hFE, 8'hEB, 6648);
        t_rate("R5 wide short doubled", 1'b1, 1'b1, 1'b1, 8'hFE, 8'hEB, 1662);
        t_idle();
        t_reload_change();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule